// File: doc/BRIEF.md
# Scaled Real-Time Counter

This block is a free-running time counter for an always-on power domain. A slow timebase, nominally 31,250 Hz, delivers a one-cycle `tick_i` pulse in the register clock domain. While counting is enabled, each pulse advances a 48-bit count by one. Software sees the count through a 32-bit register bus. It appears as a 32-bit low word and a 16-bit high word, and software can write both words to preset the count.

A 4-bit scale field picks a 32-bit window of the count, bits [scale+31:scale]. That is the count shifted right by the scale value. The window can be read as its own register. It is also compared against a 32-bit alarm value. While the window is at or above the alarm value, the pending flag in the control word is set and `irq_o` is high. The interrupt is a level: it clears when software raises the alarm value, lowers the count or changes the scale.

Top module: `rtc_scaled_counter`

## Requirements
- R1: After reset the control word (0x00), count low (0x08), count high (0x0C) and scaled window (0x10) read zero, the alarm (0x20) reads 0xFFFFFFFF and `irq_o` is low.
- R2: While the enable bit (control bit 12) is set, each cycle with `tick_i` high and no count write adds exactly one to the 48-bit count.
- R3: While the enable bit is clear, `tick_i` leaves the count unchanged.
- R4: A write to 0x08 replaces count bits [31:0] only. A write to 0x0C replaces count bits [47:32] with write data [15:0] only.
- R5: Bits [31:16] of the count-high register always read zero, and writes to them are ignored.
- R6: A count write in the same cycle as an enabled tick takes priority: the written word is stored, the other word is kept, and no increment occurs.
- R7: An increment carries from the low word into the high word, and 0xFFFF_FFFFFFFF advances to zero.
- R8: The control word holds scale in bits [3:0] and enable in bit 12, and both read back as written. All other bits of the control word read zero, except bit 28.
- R9: Register 0x10 reads count bits [scale+31:scale], that is, the count shifted right by the scale value. Writes to it are ignored.
- R10: `irq_o` and control bit 28 are high exactly while the scaled window is greater than or equal to the alarm value. Writing bit 28 has no effect.
- R11: Reads of any offset other than 0x00, 0x08, 0x0C, 0x10 and 0x20 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase pulse, synchronous to clk_i |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when no read is requested |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
On every cycle, the assertions check the following:
- single-step increments under enable;
- holding while disabled;
- the priority of a count write over a tick;
- the zero upper half of the count-high register;
- agreement between `irq_o` and the pending bit;
- zero data on unmapped reads.

The bench scenarios cover the behaviour that needs a history. These are the carry into the high word and the wrap of the full 48-bit count. They also include the choice of window by each scale value, the alarm crossing under a non-zero scale, and the writes that must be ignored. For those, the bench compares every register against a model after random sequences of writes and ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_WINDOW = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h20;

  localparam int unsigned CTRL_EN_BIT  = 12;
  localparam int unsigned CTRL_PEND_BIT = 28;

  typedef struct packed {
    logic ctrl;
    logic cnt_lo;
    logic cnt_hi;
    logic alarm;
  } wr_sel_t;

  typedef struct packed {
    logic ctrl;
    logic cnt_lo;
    logic cnt_hi;
    logic window;
    logic alarm;
  } rd_sel_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_sel_t           wsel_o,
  output rd_sel_t           rsel_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    wsel_o        = '0;
    rsel_o        = '0;
    wsel_o.ctrl   = wr && (addr_i == OFF_CTRL);
    wsel_o.cnt_lo = wr && (addr_i == OFF_CNT_LO);
    wsel_o.cnt_hi = wr && (addr_i == OFF_CNT_HI);
    wsel_o.alarm  = wr && (addr_i == OFF_ALARM);
    rsel_o.ctrl   = rd && (addr_i == OFF_CTRL);
    rsel_o.cnt_lo = rd && (addr_i == OFF_CNT_LO);
    rsel_o.cnt_hi = rd && (addr_i == OFF_CNT_HI);
    rsel_o.window = rd && (addr_i == OFF_WINDOW);
    rsel_o.alarm  = rd && (addr_i == OFF_ALARM);
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i)           cnt_d[DATA_W-1:0]     = wdata_i;
    else if (wr_hi_i)      cnt_d[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
    else if (tick_i && en_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_window_cmp.sv
module rtc_window_cmp #(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DATA_W-1:0]  alarm_i,
  output logic [DATA_W-1:0]  window_o,
  output logic               hit_o
);
  logic [CNT_W-1:0] shifted;
  assign shifted  = cnt_i >> scale_i;
  assign window_o = shifted[DATA_W-1:0];
  assign hit_o    = (window_o >= alarm_i);
endmodule

// File: rtl/rtc_scaled_counter.sv
module rtc_scaled_counter
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SCALE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  wr_sel_t              wsel;
  rd_sel_t              rsel;
  logic                 en_q;
  logic [SCALE_W-1:0]   scale_q;
  logic [DATA_W-1:0]    alarm_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [DATA_W-1:0]    window;
  logic                 hit;
  logic [DATA_W-1:0]    ctrl_rd;

  rtc_bus_decode u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wsel_o (wsel),
    .rsel_o (rsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      scale_q <= '0;
      alarm_q <= '1;
    end else begin
      if (wsel.ctrl) begin
        en_q    <= wdata_i[CTRL_EN_BIT];
        scale_q <= wdata_i[SCALE_W-1:0];
      end
      if (wsel.alarm) alarm_q <= wdata_i;
    end
  end

  rtc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (en_q),
    .wr_lo_i (wsel.cnt_lo),
    .wr_hi_i (wsel.cnt_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q)
  );

  rtc_window_cmp #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_cmp (
    .cnt_i    (cnt_q),
    .scale_i  (scale_q),
    .alarm_i  (alarm_q),
    .window_o (window),
    .hit_o    (hit)
  );

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[SCALE_W-1:0]     = scale_q;
    ctrl_rd[CTRL_EN_BIT]     = en_q;
    ctrl_rd[CTRL_PEND_BIT]   = hit;
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      rsel.ctrl:   rdata_o = ctrl_rd;
      rsel.cnt_lo: rdata_o = cnt_q[DATA_W-1:0];
      rsel.cnt_hi: rdata_o = DATA_W'(cnt_q[CNT_W-1:DATA_W]);
      rsel.window: rdata_o = window;
      rsel.alarm:  rdata_o = alarm_q;
      default:     rdata_o = '0;
    endcase
  end

  assign irq_o = hit;

  logic unused_hi;
  assign unused_hi = &{1'b0, HI_W};
endmodule

// File: rtl/rtc_scaled_counter_chk.sv
module rtc_scaled_counter_chk #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [7:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              en_i
);
  logic wr_lo, wr_hi, cnt_wr, rd;
  logic mapped;
  assign wr_lo  = req_i && we_i && (addr_i == 8'h08);
  assign wr_hi  = req_i && we_i && (addr_i == 8'h0C);
  assign cnt_wr = wr_lo || wr_hi;
  assign rd     = req_i && !we_i;
  assign mapped = (addr_i == 8'h00) || (addr_i == 8'h08) || (addr_i == 8'h0C) ||
                  (addr_i == 8'h10) || (addr_i == 8'h20);

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !cnt_wr) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr) |=> $stable(cnt_i));

  assert_lo_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (cnt_i[DATA_W-1:0] == $past(wdata_i)) &&
              (cnt_i[CNT_W-1:DATA_W] == $past(cnt_i[CNT_W-1:DATA_W])));

  assert_hi_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (cnt_i[CNT_W-1:DATA_W] == $past(wdata_i[CNT_W-DATA_W-1:0])) &&
              (cnt_i[DATA_W-1:0] == $past(cnt_i[DATA_W-1:0])));

  assert_hi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 8'h0C) |-> (rdata_o[DATA_W-1:CNT_W-DATA_W] == '0));

  assert_pend_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 8'h00) |-> (rdata_o[28] == irq_o));

  assert_unmapped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |-> (rdata_o == '0));
endmodule

bind rtc_scaled_counter rtc_scaled_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_i   (cnt_q),
  .en_i    (en_q)
);

// File: tb/tb_rtc_scaled_counter.sv
module tb_rtc_scaled_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [47:0] m_cnt;
  logic        m_en;
  logic [3:0]  m_scale;
  logic [31:0] m_alarm;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_scaled_counter dut (
    .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  function automatic logic [31:0] m_window();
    logic [47:0] s;
    s = m_cnt >> m_scale;
    return s[31:0];
  endfunction

  function automatic logic m_hit();
    return m_window() >= m_alarm;
  endfunction

  function automatic logic [31:0] m_ctrl();
    logic [31:0] c;
    c = '0;
    c[3:0] = m_scale;
    c[12]  = m_en;
    c[28]  = m_hit();
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  // write with optional tick in the same cycle; model updated alongside
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    logic old_en;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    old_en = m_en;
    if (a == 8'h08)      m_cnt[31:0]  = d;
    else if (a == 8'h0C) m_cnt[47:32] = d[15:0];
    else if (tk && old_en) m_cnt = m_cnt + 48'd1;
    if (a == 8'h00) begin m_scale = d[3:0]; m_en = d[12]; end
    if (a == 8'h20) m_alarm = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      if (m_en) m_cnt = m_cnt + 48'd1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(8'h00, d); chk({tag, " R8 ctrl"}, d, m_ctrl());
    rd(8'h08, d); chk({tag, " R4 lo"}, d, m_cnt[31:0]);
    rd(8'h0C, d); chk({tag, " R5 hi"}, d, {16'h0, m_cnt[47:32]});
    rd(8'h10, d); chk({tag, " R9 window"}, d, m_window());
    rd(8'h20, d); chk({tag, " alarm"}, d, m_alarm);
    chk({tag, " R10 irq"}, {31'h0, irq_o}, {31'h0, m_hit()});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_cnt = '0; m_en = 1'b0; m_scale = '0; m_alarm = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check_all("R1 reset");

    // R3 disabled ticks ignored
    ticks(5);
    rd(8'h08, d); chk("R3 disabled lo", d, 32'h0);

    // R2 enabled counting
    wr(8'h00, 32'h0000_1000, 1'b0);
    ticks(7);
    rd(8'h08, d); chk("R2 count lo", d, 32'd7);

    // R8 other control bits read zero, R10 pend write ignored
    wr(8'h00, 32'hFFFF_EFF3 | 32'h1000, 1'b0);
    rd(8'h00, d); chk("R8 R10 ctrl mask", d, m_ctrl());

    // R7 carry and full wrap
    wr(8'h00, 32'h0000_1000, 1'b0);
    wr(8'h0C, 32'hABCD_0012, 1'b0);
    rd(8'h0C, d); chk("R5 hi upper zero", d, 32'h0000_0012);
    wr(8'h08, 32'hFFFF_FFFF, 1'b0);
    ticks(1);
    check_all("R7 carry");
    wr(8'h0C, 32'h0000_FFFF, 1'b0);
    wr(8'h08, 32'hFFFF_FFFF, 1'b0);
    ticks(1);
    rd(8'h08, d); chk("R7 wrap lo", d, 32'h0);
    rd(8'h0C, d); chk("R7 wrap hi", d, 32'h0);

    // R6 write wins over tick
    wr(8'h08, 32'h0000_0100, 1'b1);
    rd(8'h08, d); chk("R6 lo write wins", d, 32'h0000_0100);
    wr(8'h0C, 32'h0000_0005, 1'b1);
    rd(8'h08, d); chk("R6 hi write no inc", d, 32'h0000_0100);
    rd(8'h0C, d); chk("R6 hi stored", d, 32'h0000_0005);

    // R9 R10 scaled alarm crossing
    wr(8'h0C, 32'h0, 1'b0);
    wr(8'h08, 32'h0000_00FF, 1'b0);
    wr(8'h00, 32'h0000_1004, 1'b0);
    wr(8'h20, 32'h0000_0010, 1'b0);
    chk("R10 below alarm", {31'h0, irq_o}, 32'h0);
    ticks(1);
    chk("R10 at alarm", {31'h0, irq_o}, 32'h1);
    rd(8'h10, d); chk("R9 window scale4", d, 32'h0000_0010);

    // R9 window write ignored, R11 unmapped
    wr(8'h10, 32'h1234_5678, 1'b0);
    wr(8'h04, 32'hFFFF_FFFF, 1'b0);
    wr(8'h24, 32'hFFFF_FFFF, 1'b0);
    check_all("R9 R11 ignored writes");
    rd(8'h04, d); chk("R11 unmapped read", d, 32'h0);
    rd(8'h3C, d); chk("R11 unmapped read hi", d, 32'h0);

    // every scale value selects its window
    wr(8'h0C, 32'h0000_9A5C, 1'b0);
    wr(8'h08, 32'h3C71_E2B4, 1'b0);
    for (int s = 0; s < 16; s++) begin
      wr(8'h00, 32'(s), 1'b0);
      rd(8'h10, d); chk("R9 scale sweep", d, m_window());
    end

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 7);
      v = $urandom;
      case (op)
        0: wr(8'h08, v, 1'($urandom % 2));
        1: wr(8'h0C, v, 1'($urandom % 2));
        2: wr(8'h00, v, 1'($urandom % 2));
        3: wr(8'h20, (($urandom % 2) == 0) ? (v & 32'h0000_03FF) : v, 1'b0);
        4: ticks(int'($urandom % 20));
        5: wr(8'h08, 32'hFFFF_FFF0 | (v & 32'hF), 1'b0);
        default: wr(8'h00, 32'h0000_1000 | (v & 32'hF), 1'b1);
      endcase
      check_all("R2 R4 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule